// File: doc/BRIEF.md
# Endian-Switchable Load/Store Lane Aligner

This block sits between a 32-bit processor core and a byte-addressed 32-bit data memory. For each request it takes the access size (8, 16 or 32 bits), the low address bits and a byte-order select. For a load it picks the right byte lanes out of the memory word and widens the result with sign or zero fill. For a store it moves the core's data onto the lanes the access covers and raises one write strobe per lane.

Byte order is chosen per request by an input, so software can switch it at run time. An access whose address is not a multiple of its size is not split. It is flagged with a fault pulse, and it gets no strobes and zero data. The datapath is combinational. A parameter adds one register stage on all outputs, and that stage is on by default.

Top module: `lsalign_top`

## Requirements
- R1: With the output stage enabled, a synchronous active-high reset drives `out_valid`, `out_fault`, `mem_wstrb`, `mem_wdata` and `load_data` to zero.
- R2: Size code 0 is 8 bits, 1 is 16 bits, 2 is 32 bits, and 3 is illegal. A 16-bit access is misaligned when offset bit 0 is set. A 32-bit access is misaligned when the offset is not 0. An 8-bit access is never misaligned. Size code 3 is always treated as misaligned.
- R3: A valid misaligned request gives `out_fault` high for exactly that request's output cycle. In that cycle `mem_wstrb`, `mem_wdata` and `load_data` are all zero.
- R4: Little-endian (`big_endian`=0): the byte at offset o is on memory bits [8o+7:8o], and the byte at the lower address is the less significant one.
- R5: Big-endian (`big_endian`=1): the byte at offset o is on memory bits [31-8o:24-8o], and the byte at the lower address is the more significant one.
- R6: A valid aligned 8- or 16-bit load fills the upper bits with the result's top bit when `req_signed`=1, and with zeros when it is 0. A 32-bit load is returned unchanged.
- R7: A valid aligned store sets exactly the `mem_wstrb` bits of the lanes it covers (bit i covers bits [8i+7:8i]). Loads, idle cycles and faults give a strobe of zero.
- R8: A valid aligned store puts its data bytes on the covered lanes, per R4/R5, and zeros on all other lanes. `load_data` is zero unless a valid aligned load is returned.
- R9: With the output stage enabled, each request's results appear one clock after it is presented, and `out_valid` repeats `req_valid` with that delay.
- R10: Byte order is taken from `big_endian` for each request, so consecutive requests may use different orders.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_is_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Size code: 0 byte, 1 half, 2 word, 3 illegal |
| req_signed | input | 1 | Sign-extend narrow loads |
| big_endian | input | 1 | Byte order select for this request |
| req_off | input | 2 | Low address bits (offset within the word) |
| req_wdata | input | 32 | Store value, right-justified |
| mem_rdata | input | 32 | Memory word read for this load |
| out_valid | output | 1 | Results below belong to a request |
| out_fault | output | 1 | Misaligned access pulse |
| mem_wstrb | output | 4 | Per-lane write strobes |
| mem_wdata | output | 32 | Store data on memory lanes |
| load_data | output | 32 | Extended load result |

## Verification
The assertions assume that `mem_rdata` belongs to the load being presented in the same cycle. They also assume that `req_size`, `req_off` and `big_endian` are stable for the whole cycle in which `req_valid` is high. The bench changes every input only on the falling clock edge. It walks through all sizes, offsets and both byte orders, including the illegal size code. It then issues random requests and flips the byte order between consecutive requests, so that R10 is exercised.

// File: rtl/lsalign_pkg.sv
package lsalign_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;
endpackage

// File: rtl/lsalign_decode.sv
module lsalign_decode
  import lsalign_pkg::*;
#(
  parameter int LANES = 4,
  parameter int OFF_W = 2
) (
  input  acc_size_e        size,
  input  logic [OFF_W-1:0] off,
  input  logic             big_end,
  output logic             misal,
  output logic [OFF_W-1:0] shift,
  output logic [LANES-1:0] lane_mask
);
  logic [OFF_W:0] nb;

  always_comb begin
    case (size)
      SZ_BYTE: nb = (OFF_W+1)'(1);
      SZ_HALF: nb = (OFF_W+1)'(2);
      default: nb = (OFF_W+1)'(LANES);
    endcase
  end

  // Natural alignment: offset must be a multiple of the access size.
  assign misal = (size == SZ_BAD) || ((({1'b0, off}) & (nb - 1'b1)) != '0);

  // Lowest lane the access occupies; in big-endian the low address is the high lane.
  assign shift = big_end ? OFF_W'(LANES - int'(off) - int'(nb)) : off;

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      lane_mask[i] = !misal && (i >= int'(shift)) && (i < int'(shift) + int'(nb));
    end
  end
endmodule

// File: rtl/lsalign_load.sv
module lsalign_load
  import lsalign_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 2
) (
  input  logic [DATA_W-1:0] rdata,
  input  logic [OFF_W-1:0]  shift,
  input  acc_size_e         size,
  input  logic              sext,
  output logic [DATA_W-1:0] value
);
  logic [DATA_W-1:0] aligned;

  assign aligned = rdata >> (8 * int'(shift));

  always_comb begin
    case (size)
      SZ_BYTE: value = {{(DATA_W-8){sext & aligned[7]}}, aligned[7:0]};
      SZ_HALF: value = {{(DATA_W-16){sext & aligned[15]}}, aligned[15:0]};
      default: value = aligned;
    endcase
  end
endmodule

// File: rtl/lsalign_store.sv
module lsalign_store #(
  parameter int DATA_W = 32,
  parameter int LANES  = 4,
  parameter int OFF_W  = 2
) (
  input  logic [DATA_W-1:0] wval,
  input  logic [OFF_W-1:0]  shift,
  input  logic [LANES-1:0]  lane_mask,
  output logic [DATA_W-1:0] wdata
);
  logic [DATA_W-1:0] placed;

  assign placed = wval << (8 * int'(shift));

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign wdata[8*i +: 8] = lane_mask[i] ? placed[8*i +: 8] : 8'h00;
  end
endmodule

// File: rtl/lsalign_top.sv
module lsalign_top
  import lsalign_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           req_valid,
  input  logic                           req_is_store,
  input  logic [1:0]                     req_size,
  input  logic                           req_signed,
  input  logic                           big_endian,
  input  logic [$clog2(DATA_W/8)-1:0]    req_off,
  input  logic [DATA_W-1:0]              req_wdata,
  input  logic [DATA_W-1:0]              mem_rdata,
  output logic                           out_valid,
  output logic                           out_fault,
  output logic [DATA_W/8-1:0]            mem_wstrb,
  output logic [DATA_W-1:0]              mem_wdata,
  output logic [DATA_W-1:0]              load_data
);
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  acc_size_e         size;
  logic              misal;
  logic [OFF_W-1:0]  shift;
  logic [LANES-1:0]  lane_mask;
  logic [DATA_W-1:0] ld_val;
  logic [DATA_W-1:0] st_val;

  logic              c_fault;
  logic [LANES-1:0]  c_strb;
  logic [DATA_W-1:0] c_wdata;
  logic [DATA_W-1:0] c_ldata;
  logic              do_store;
  logic              do_load;

  assign size = acc_size_e'(req_size);

  lsalign_decode #(.LANES(LANES), .OFF_W(OFF_W)) u_decode (
    .size     (size),
    .off      (req_off),
    .big_end  (big_endian),
    .misal    (misal),
    .shift    (shift),
    .lane_mask(lane_mask)
  );

  lsalign_load #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_load (
    .rdata(mem_rdata),
    .shift(shift),
    .size (size),
    .sext (req_signed),
    .value(ld_val)
  );

  lsalign_store #(.DATA_W(DATA_W), .LANES(LANES), .OFF_W(OFF_W)) u_store (
    .wval     (req_wdata),
    .shift    (shift),
    .lane_mask(lane_mask),
    .wdata    (st_val)
  );

  assign do_store = req_valid && req_is_store && !misal;
  assign do_load  = req_valid && !req_is_store && !misal;
  assign c_fault  = req_valid && misal;
  assign c_strb   = do_store ? lane_mask : '0;
  assign c_wdata  = do_store ? st_val : '0;
  assign c_ldata  = do_load ? ld_val : '0;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        out_valid <= 1'b0;
        out_fault <= 1'b0;
        mem_wstrb <= '0;
        mem_wdata <= '0;
        load_data <= '0;
      end else begin
        out_valid <= req_valid;
        out_fault <= c_fault;
        mem_wstrb <= c_strb;
        mem_wdata <= c_wdata;
        load_data <= c_ldata;
      end
    end

    AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(req_valid)); // R9
  end else begin : g_comb
    assign out_valid = req_valid;
    assign out_fault = c_fault;
    assign mem_wstrb = c_strb;
    assign mem_wdata = c_wdata;
    assign load_data = c_ldata;
  end

  AST_FAULT_NO_STRB: assert property (@(posedge clk) disable iff (rst)
    out_fault |-> (mem_wstrb == '0 && mem_wdata == '0 && load_data == '0)); // R3
  AST_FAULT_HAS_VALID: assert property (@(posedge clk) disable iff (rst)
    out_fault |-> out_valid); // R3
  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && size == SZ_BYTE) |-> $onehot0(c_strb)); // R7
  AST_LOAD_NO_STRB: assert property (@(posedge clk) disable iff (rst)
    !req_is_store |-> (c_strb == '0)); // R7
  AST_WORD_ALL_LANES: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_is_store && size == SZ_WORD && req_off == '0) |-> (c_strb == '1)); // R7
  AST_ODD_HALF_FAULT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && size == SZ_HALF && req_off[0]) |-> (c_fault && c_strb == '0)); // R2
endmodule

// File: tb/lsalign_top_bench.sv
`timescale 1ns/1ps
module lsalign_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_is_store = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic        req_signed = 1'b0;
  logic        big_endian = 1'b0;
  logic [1:0]  req_off = 2'd0;
  logic [31:0] req_wdata = '0;
  logic [31:0] mem_rdata = '0;
  logic        out_valid;
  logic        out_fault;
  logic [3:0]  mem_wstrb;
  logic [31:0] mem_wdata;
  logic [31:0] load_data;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  // Expected results for the request presented at the previous falling edge.
  logic        e_valid = 1'b0, e_fault = 1'b0;
  logic [3:0]  e_strb = '0;
  logic [31:0] e_wdata = '0, e_ldata = '0;
  string       tag_ld = "R4", tag_st = "R8", tag_sb = "R7";

  always #5 clk = ~clk;

  lsalign_top u_lsalign_top (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_is_store(req_is_store),
    .req_size(req_size), .req_signed(req_signed), .big_endian(big_endian),
    .req_off(req_off), .req_wdata(req_wdata), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_fault(out_fault), .mem_wstrb(mem_wstrb),
    .mem_wdata(mem_wdata), .load_data(load_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural model of one request, built from the requirements.
  task automatic model(input logic v, input logic st, input logic [1:0] sz, input logic sg,
                       input logic be, input logic [1:0] off, input logic [31:0] wd,
                       input logic [31:0] rd);
    int nb;
    bit mis;
    logic [31:0] val, wo;
    logic [3:0] sb;
    nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : (sz == 2'd2) ? 4 : 0;
    mis = (nb == 0) || ((int'(off) % nb) != 0);
    val = '0; wo = '0; sb = '0;
    if (!mis) begin
      for (int i = 0; i < nb; i++) begin
        int a, lane, sig;
        a = int'(off) + i;
        lane = be ? 3 - a : a;
        sig = be ? nb - 1 - i : i;
        val[8*sig +: 8] = rd[8*lane +: 8];
        wo[8*lane +: 8] = wd[8*sig +: 8];
        sb[lane] = 1'b1;
      end
      if (sg && nb < 4) begin
        for (int b = 8*nb; b < 32; b++) val[b] = val[8*nb-1];
      end
    end
    e_valid = v;
    e_fault = v && mis;
    e_strb  = (v && st && !mis) ? sb : 4'h0;
    e_wdata = (v && st && !mis) ? wo : 32'h0;
    e_ldata = (v && !st && !mis) ? val : 32'h0;
    if (v && mis) begin
      tag_ld = "R3"; tag_st = "R3"; tag_sb = "R3";
    end else begin
      tag_ld = (sg && nb < 4 && !st) ? "R6" : (be ? "R5/R10" : "R4");
      tag_st = be ? "R8/R5" : "R8/R4";
      tag_sb = "R7";
    end
  endtask

  // At a falling edge: compare the previous request's results, then present a new one.
  task automatic step(input logic v, input logic st, input logic [1:0] sz, input logic sg,
                      input logic be, input logic [1:0] off, input logic [31:0] wd,
                      input logic [31:0] rd);
    @(negedge clk);
    chk("R9 out_valid", {31'b0, out_valid}, {31'b0, e_valid});
    chk("R2/R3 out_fault", {31'b0, out_fault}, {31'b0, e_fault});
    chk({tag_sb, " mem_wstrb"}, {28'b0, mem_wstrb}, {28'b0, e_strb});
    chk({tag_st, " mem_wdata"}, mem_wdata, e_wdata);
    chk({tag_ld, " load_data"}, load_data, e_ldata);
    req_valid = v; req_is_store = st; req_size = sz; req_signed = sg;
    big_endian = be; req_off = off; req_wdata = wd; mem_rdata = rd;
    model(v, st, sz, sg, be, off, wd, rd);
  endtask

  initial begin
    // R1: outputs held at zero under reset, even with a request at the inputs
    req_valid = 1'b1; req_is_store = 1'b1; req_size = 2'd2; req_wdata = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 out_valid", {31'b0, out_valid}, 32'h0);
    chk("R1 out_fault", {31'b0, out_fault}, 32'h0);
    chk("R1 mem_wstrb", {28'b0, mem_wstrb}, 32'h0);
    chk("R1 mem_wdata", mem_wdata, 32'h0);
    chk("R1 load_data", load_data, 32'h0);
    req_valid = 1'b0;
    model(1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 32'h0, 32'h0);
    rst = 1'b0;

    // R4/R5: byte loads at every offset in both orders
    for (int be = 0; be < 2; be++)
      for (int o = 0; o < 4; o++)
        step(1'b1, 1'b0, 2'd0, 1'b0, 1'(be), 2'(o), 32'h0, 32'h8A4B_2C1D);
    // R6: signed and unsigned narrow loads of negative values
    step(1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 2'd3, 32'h0, 32'h80FF_0102);
    step(1'b1, 1'b0, 2'd1, 1'b1, 1'b1, 2'd0, 32'h0, 32'hC123_4567);
    step(1'b1, 1'b0, 2'd1, 1'b0, 1'b1, 2'd0, 32'h0, 32'hC123_4567);
    step(1'b1, 1'b0, 2'd1, 1'b1, 1'b0, 2'd2, 32'h0, 32'hC123_4567);
    step(1'b1, 1'b0, 2'd2, 1'b1, 1'b1, 2'd0, 32'h0, 32'hF000_0001);
    // R7/R8: stores of each size, both orders
    for (int be = 0; be < 2; be++) begin
      for (int o = 0; o < 4; o++)
        step(1'b1, 1'b1, 2'd0, 1'b0, 1'(be), 2'(o), 32'h1234_56A5, 32'h0);
      step(1'b1, 1'b1, 2'd1, 1'b0, 1'(be), 2'd0, 32'hDEAD_BEEF, 32'h0);
      step(1'b1, 1'b1, 2'd1, 1'b0, 1'(be), 2'd2, 32'hDEAD_BEEF, 32'h0);
      step(1'b1, 1'b1, 2'd2, 1'b0, 1'(be), 2'd0, 32'hDEAD_BEEF, 32'h0);
    end
    // R2/R3: misaligned halves and words, illegal size, loads and stores
    step(1'b1, 1'b1, 2'd1, 1'b0, 1'b0, 2'd1, 32'hFFFF_FFFF, 32'h0);
    step(1'b1, 1'b0, 2'd1, 1'b1, 1'b1, 2'd3, 32'h0, 32'hFFFF_FFFF);
    step(1'b1, 1'b1, 2'd2, 1'b0, 1'b1, 2'd2, 32'hFFFF_FFFF, 32'h0);
    step(1'b1, 1'b0, 2'd2, 1'b0, 1'b0, 2'd1, 32'h0, 32'hFFFF_FFFF);
    step(1'b1, 1'b1, 2'd3, 1'b0, 1'b0, 2'd0, 32'hFFFF_FFFF, 32'h0);
    // R3: fault lasts one cycle; an idle cycle follows
    step(1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 2'd1, 32'hFFFF_FFFF, 32'h0);
    // R10: identical requests back to back with the byte order flipped
    step(1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 2'd0, 32'h0, 32'h1122_3344);
    step(1'b1, 1'b0, 2'd1, 1'b0, 1'b1, 2'd0, 32'h0, 32'h1122_3344);
    step(1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 2'd1, 32'h0000_0077, 32'h0);
    step(1'b1, 1'b1, 2'd0, 1'b0, 1'b1, 2'd1, 32'h0000_0077, 32'h0);
    // Random traffic; the byte order changes freely between requests (R10)
    for (int n = 0; n < 2000; n++)
      step(1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
           2'($urandom), $urandom, $urandom);
    step(1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 32'h0, 32'h0);
    step(1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 32'h0, 32'h0);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule